// File: doc/BRIEF.md
# Conditional Compare and Select Unit

This unit carries out the two condition-driven integer operations of a 64-bit datapath. It tests a 4-bit condition code against the current N, Z, C and V flags. A conditional compare updates the flags. If the condition holds, the new flags come from an add or a subtract of the two operands. If it fails, the new flags are a 4-bit default value given with the operation. A conditional select produces a register result. If the condition holds, that result is the first operand. If it fails, it is a transformed copy of the second operand.

The second compare operand is either the register operand or a small unsigned immediate, chosen per operation. Every operation can run at the full width or at half width. At half width the flags come from the low half of the data, and a select result is zero-extended. Each cycle the unit evaluates whatever sits on its inputs and registers the outcome. The new result and flags appear one clock edge later.

Top module: `ccs_unit`

## Requirements
- R1: The condition `cond` is tested on `flags_in` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). `cond[3:1]` picks the base test: 000 Z set, 001 C set, 010 N set, 011 V set, 100 C set and Z clear, 101 N equal to V, 110 Z clear and N equal to V, 111 always true. When `cond[0]` is 1 the base test is inverted, except for code 1111, which is always true.
- R2: A compare is selected by `op_is_sel`=0. When its condition holds, `flags_q` takes N and Z of the result and C and V from the operation. `op_mode[0]`=0 subtracts (op_a − operand, C = no borrow). `op_mode[0]`=1 adds (op_a + operand, C = carry out). V is signed overflow in both cases.
- R3: When a compare's condition fails, `flags_q` takes `dflt_nzcv` exactly, in the same bit layout as `flags_in`.
- R4: With `use_imm`=1, the compare's second operand is `cmp_imm`, zero-extended, and `op_b` has no effect. With `use_imm`=0 it is `op_b`.
- R5: A select is selected by `op_is_sel`=1. When its condition holds, `res_q` takes `op_a`.
- R6: When a select's condition fails, `res_q` depends on `op_mode`: 00 gives `op_b`, 01 gives `op_b`+1, 10 gives the bitwise inverse of `op_b`, 11 gives the two's-complement negation of `op_b`.
- R7: A compare leaves `res_q` at its previous value. A select sets `flags_q` to `flags_in`, unchanged.
- R8: With `wide`=0, compare flags are formed from bits [31:0] (N from bit 31, C out of bit 31, Z on the low 32 bits). A select result is bits [31:0] with bits [63:32] cleared.
- R9: Reset (`rst_n` low, asynchronous) clears `res_q` and `flags_q`. Any operation shows on the outputs at the first rising edge after its inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_is_sel | input | 1 | 1 = conditional select, 0 = conditional compare |
| op_mode | input | 2 | Select: alternative transform. Compare: bit 0 picks add |
| use_imm | input | 1 | Compare takes the immediate as its second operand |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| cond | input | 4 | Condition code |
| dflt_nzcv | input | 4 | Flags loaded when a compare's condition fails |
| flags_in | input | 4 | Current N, Z, C, V flags |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second register operand |
| cmp_imm | input | 5 | Unsigned compare immediate |
| res_q | output | 64 | Registered select result |
| flags_q | output | 4 | Registered new flags |

## Verification
The assertions assume that every input is a known value on each rising edge outside reset, and that the caller holds the inputs of an operation through the edge that captures it. The bench changes inputs only on the falling edge and drives every field of every vector, including the fields the operation ignores. The checks on held values rely on the rule that a compare keeps the previous result. For that reason the vectors run as one continuous sequence, and the bench carries the last selected result forward as the expected value.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [1:0] {
        ALT_COPY = 2'b00,
        ALT_INC  = 2'b01,
        ALT_INV  = 2'b10,
        ALT_NEG  = 2'b11
    } alt_mode_e;

    typedef enum logic [2:0] {
        BASE_Z    = 3'b000,
        BASE_C    = 3'b001,
        BASE_N    = 3'b010,
        BASE_V    = 3'b011,
        BASE_HI   = 3'b100,
        BASE_GE   = 3'b101,
        BASE_GT   = 3'b110,
        BASE_TRUE = 3'b111
    } cond_base_e;

endpackage

// File: rtl/ccs_cond_eval.sv
module ccs_cond_eval
    import ccs_pkg::*;
(
    input  logic [3:0] cond,
    input  nzcv_t      flags,
    output logic       holds
);

    logic base;

    always_comb begin
        unique case (cond_base_e'(cond[3:1]))
            BASE_Z:    base = flags.z;
            BASE_C:    base = flags.c;
            BASE_N:    base = flags.n;
            BASE_V:    base = flags.v;
            BASE_HI:   base = flags.c & ~flags.z;
            BASE_GE:   base = (flags.n == flags.v);
            BASE_GT:   base = ~flags.z & (flags.n == flags.v);
            default:   base = 1'b1;
        endcase
        // Odd codes invert the base test; the all-ones code stays true (R1)
        holds = (cond[0] && (cond != 4'hF)) ? ~base : base;
    end

endmodule

// File: rtl/ccs_addsub_flags.sv
module ccs_addsub_flags
    import ccs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              wide,
    output nzcv_t             flags
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_w;
    logic [HALF_W:0]   sum_h;

    always_comb begin
        b_eff = sub ? ~b : b;
        sum_w = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        sum_h = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
              + {{HALF_W{1'b0}}, sub};
        if (wide) begin
            flags.n = sum_w[DATA_W-1];
            flags.z = (sum_w[DATA_W-1:0] == '0);
            flags.c = sum_w[DATA_W];
            flags.v = (a[DATA_W-1] == b_eff[DATA_W-1])
                   && (sum_w[DATA_W-1] != a[DATA_W-1]);
        end else begin
            flags.n = sum_h[HALF_W-1];
            flags.z = (sum_h[HALF_W-1:0] == '0);
            flags.c = sum_h[HALF_W];
            flags.v = (a[HALF_W-1] == b_eff[HALF_W-1])
                   && (sum_h[HALF_W-1] != a[HALF_W-1]);
        end
    end

endmodule

// File: rtl/ccs_alt_value.sv
module ccs_alt_value
    import ccs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] b,
    input  alt_mode_e         mode,
    output logic [DATA_W-1:0] alt
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (mode)
            ALT_COPY: alt = b;
            ALT_INC:  alt = b + ONE;
            ALT_INV:  alt = ~b;
            default:  alt = ~b + ONE;
        endcase
    end

endmodule

// File: rtl/ccs_unit.sv
module ccs_unit
    import ccs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_is_sel,
    input  logic [1:0]        op_mode,
    input  logic              use_imm,
    input  logic              wide,
    input  logic [3:0]        cond,
    input  logic [3:0]        dflt_nzcv,
    input  logic [3:0]        flags_in,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [IMM_W-1:0]  cmp_imm,
    output logic [DATA_W-1:0] res_q,
    output logic [3:0]        flags_q
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        nzcv_t             flags;
    } state_t;

    state_t            st_d, st_q;
    logic              cond_holds;
    nzcv_t             calc_flags;
    logic [DATA_W-1:0] cmp_opnd;
    logic [DATA_W-1:0] alt_val;

    assign cmp_opnd = use_imm ? {{(DATA_W-IMM_W){1'b0}}, cmp_imm} : op_b;

    ccs_cond_eval u_cond (
        .cond  (cond),
        .flags (nzcv_t'(flags_in)),
        .holds (cond_holds)
    );

    ccs_addsub_flags #(.DATA_W(DATA_W)) u_flags (
        .a     (op_a),
        .b     (cmp_opnd),
        .sub   (~op_mode[0]),
        .wide  (wide),
        .flags (calc_flags)
    );

    ccs_alt_value #(.DATA_W(DATA_W)) u_alt (
        .b    (op_b),
        .mode (alt_mode_e'(op_mode)),
        .alt  (alt_val)
    );

    always_comb begin
        st_d = st_q;
        if (op_is_sel) begin
            st_d.res   = cond_holds ? op_a : alt_val;
            if (!wide) begin
                st_d.res[DATA_W-1:HALF_W] = '0;
            end
            st_d.flags = nzcv_t'(flags_in);
        end else begin
            st_d.flags = cond_holds ? calc_flags : nzcv_t'(dflt_nzcv);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q   = st_q.res;
    assign flags_q = st_q.flags;

    // Failed compare condition loads the default nibble
    p_cmp_fail_dflt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_is_sel && !cond_holds) |=> (flags_q == $past(dflt_nzcv)));

    // Taken select returns the first operand, masked at half width
    p_sel_take_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_is_sel && cond_holds && wide) |=> (res_q == $past(op_a)));

    // Always-true codes take the first operand on a select
    p_always_true_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_is_sel && (cond[3:1] == 3'b111) && wide) |=> (res_q == $past(op_a)));

    // Compare holds the result, select passes the flags through
    p_cmp_keeps_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_is_sel |=> $stable(res_q));

    p_sel_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_sel |=> (flags_q == $past(flags_in)));

    // Half-width select clears the upper half
    p_narrow_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_is_sel && !wide) |=> (res_q[DATA_W-1:HALF_W] == '0));

    // Immediate form ignores the register operand: equal compare gives Z
    p_imm_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_is_sel && cond_holds && use_imm && wide && !op_mode[0]
         && (op_a == {{(DATA_W-IMM_W){1'b0}}, cmp_imm})) |=> (flags_q == 4'b0110));

endmodule

// File: tb/ccs_unit_bench.sv
`timescale 1ns/1ps
module ccs_unit_bench;

    typedef struct packed {
        logic        is_sel;
        logic [1:0]  mode;
        logic        use_imm;
        logic        wide;
        logic [3:0]  cond;
        logic [3:0]  dflt;
        logic [3:0]  fin;
        logic [63:0] a;
        logic [63:0] b;
        logic [4:0]  imm;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 26;

    // exp: select rows = result, compare rows = flags in bits [3:0]
    localparam vec_t VECS [NVEC] = '{
        // R2 subtract, equal operands
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'hE, 4'h0, 4'h0, 64'd5, 64'd5, 5'd0, 64'h6, 4'd2},
        // R2 subtract with borrow
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'hE, 4'h0, 4'h0, 64'd3, 64'd5, 5'd0, 64'h8, 4'd2},
        // R2 add, signed overflow
        '{1'b0, 2'd1, 1'b0, 1'b1, 4'hE, 4'h0, 4'h0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 64'h9, 4'd2},
        // R2 add, carry out to zero
        '{1'b0, 2'd1, 1'b0, 1'b1, 4'hE, 4'h0, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 64'h6, 4'd2},
        // R8 half-width subtract ignores upper bits
        '{1'b0, 2'd0, 1'b0, 1'b0, 4'hE, 4'h0, 4'h0, 64'h1_0000_0005, 64'd5, 5'd0, 64'h6, 4'd8},
        // R8 half-width add overflow at bit 31
        '{1'b0, 2'd1, 1'b0, 1'b0, 4'hE, 4'h0, 4'h0, 64'h7FFF_FFFF, 64'd1, 5'd0, 64'h9, 4'd8},
        // R4 immediate operand replaces op_b
        '{1'b0, 2'd0, 1'b1, 1'b1, 4'hE, 4'h0, 4'h0, 64'd31, 64'd7, 5'd31, 64'h6, 4'd4},
        // R4 register operand when use_imm is low
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'hE, 4'h0, 4'h0, 64'd31, 64'd7, 5'd31, 64'h2, 4'd4},
        // R3 EQ false loads default
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'h0, 4'hA, 4'h0, 64'd1, 64'd1, 5'd0, 64'hA, 4'd3},
        // R1 NE true
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'h1, 4'hF, 4'h0, 64'd1, 64'd2, 5'd0, 64'h8, 4'd1},
        // R1 GE false (N!=V)
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'hA, 4'h5, 4'h8, 64'd0, 64'd0, 5'd0, 64'h5, 4'd1},
        // R1 code 1111 always true
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'hF, 4'hF, 4'h0, 64'd2, 64'd1, 5'd0, 64'h2, 4'd1},
        // R1 HI true
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'h8, 4'hF, 4'h2, 64'd0, 64'd0, 5'd0, 64'h6, 4'd1},
        // R1 VS true
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'h6, 4'hF, 4'h1, 64'd0, 64'd0, 5'd0, 64'h6, 4'd1},
        // R1 MI false
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'h4, 4'h3, 4'h0, 64'd0, 64'd0, 5'd0, 64'h3, 4'd1},
        // R1 GT false on Z set
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'hC, 4'hF, 4'h4, 64'd0, 64'd0, 5'd0, 64'hF, 4'd1},
        // R3 CS false loads default
        '{1'b0, 2'd0, 1'b0, 1'b1, 4'h2, 4'hC, 4'h0, 64'd9, 64'd1, 5'd0, 64'hC, 4'd3},
        // R5 select taken
        '{1'b1, 2'd3, 1'b0, 1'b1, 4'hE, 4'h0, 4'h3, 64'h1234, 64'h9, 5'd0, 64'h1234, 4'd5},
        // R6 copy
        '{1'b1, 2'd0, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 64'h77, 64'hABCD, 5'd0, 64'hABCD, 4'd6},
        // R6 increment wraps
        '{1'b1, 2'd1, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 64'h77, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, 64'h0, 4'd6},
        // R6 invert
        '{1'b1, 2'd2, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 64'h77, 64'h0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd6},
        // R6 negate
        '{1'b1, 2'd3, 1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 64'h77, 64'h1, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd6},
        // R8 half-width invert
        '{1'b1, 2'd2, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 64'h77, 64'h0, 5'd0, 64'hFFFF_FFFF, 4'd8},
        // R8 half-width taken select
        '{1'b1, 2'd0, 1'b0, 1'b0, 4'hE, 4'h0, 4'hF, 64'hDEAD_BEEF_1234_5678, 64'h0, 5'd0, 64'h1234_5678, 4'd8},
        // R1 LT true selects op_a
        '{1'b1, 2'd0, 1'b0, 1'b1, 4'hB, 4'h0, 4'h8, 64'h55, 64'h66, 5'd0, 64'h55, 4'd1},
        // R1 LE false selects op_b
        '{1'b1, 2'd0, 1'b0, 1'b1, 4'hD, 4'h0, 4'h0, 64'h55, 64'h66, 5'd0, 64'h66, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_is_sel = 1'b0;
    logic [1:0]  op_mode = 2'd0;
    logic        use_imm = 1'b0;
    logic        wide = 1'b1;
    logic [3:0]  cond = 4'h0;
    logic [3:0]  dflt_nzcv = 4'h0;
    logic [3:0]  flags_in = 4'h0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [4:0]  cmp_imm = '0;
    logic [63:0] res_q;
    logic [3:0]  flags_q;

    int checks = 0;
    int fails = 0;
    logic [63:0] kept_res = '0;

    always #4 clk = ~clk;

    ccs_unit u_ccs_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_is_sel (op_is_sel),
        .op_mode   (op_mode),
        .use_imm   (use_imm),
        .wide      (wide),
        .cond      (cond),
        .dflt_nzcv (dflt_nzcv),
        .flags_in  (flags_in),
        .op_a      (op_a),
        .op_b      (op_b),
        .cmp_imm   (cmp_imm),
        .res_q     (res_q),
        .flags_q   (flags_q)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        op_is_sel = v.is_sel;
        op_mode   = v.mode;
        use_imm   = v.use_imm;
        wide      = v.wide;
        cond      = v.cond;
        dflt_nzcv = v.dflt;
        flags_in  = v.fin;
        op_a      = v.a;
        op_b      = v.b;
        cmp_imm   = v.imm;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        vec_t v;
        string tag;
        repeat (3) @(negedge clk);
        // R9 reset state
        check64("R9 reset res", res_q, 64'd0);
        check64("R9 reset flags", {60'd0, flags_q}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            @(negedge clk);
            apply(v);
            @(negedge clk);
            tag = $sformatf("R%0d row %0d", v.req, i);
            if (v.is_sel) begin
                kept_res = v.exp;
                check64({tag, " res"}, res_q, kept_res);
                // R7 select passes flags through
                check64({tag, " R7 flags"}, {60'd0, flags_q}, {60'd0, v.fin});
            end else begin
                check64({tag, " flags"}, {60'd0, flags_q}, {60'd0, v.exp[3:0]});
                // R7 compare keeps the earlier result
                check64({tag, " R7 res"}, res_q, kept_res);
            end
        end

        // R9 one-edge latency: unchanged before the edge, updated after
        @(negedge clk);
        apply('{1'b1, 2'd0, 1'b0, 1'b1, 4'hE, 4'h0, 4'h0, 64'h99, 64'h0, 5'd0, 64'h0, 4'd9});
        #1;
        check64("R9 before edge", res_q, kept_res);
        @(negedge clk);
        check64("R9 after edge", res_q, 64'h99);

        // R4 immediate form: op_b change has no effect on flags
        @(negedge clk);
        apply('{1'b0, 2'd0, 1'b1, 1'b1, 4'hE, 4'h0, 4'h0, 64'd4, 64'd4, 5'd9, 64'h0, 4'd4});
        @(negedge clk);
        check64("R4 imm 4-9 flags", {60'd0, flags_q}, 64'h8);

        // R9 asynchronous reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check64("R9 mid reset res", res_q, 64'd0);
        check64("R9 mid reset flags", {60'd0, flags_q}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule